// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the even parity bit that accompanies a 32-bit multiplexed address/data bus with 4 command/byte-enable lines, as used by a PCI agent. Each clock it folds the bus lines into one parity bit and presents it one clock later. The parity pin is enabled whenever the agent drove the address/data lines in the previous clock. The enclosing agent says which clocks it drives through `ad_oe`.

When the agent receives a phase, the block compares the incoming parity with its own value on the following clock. An address phase is the first clock in which frame is low. A data phase counts only on a clock where initiator-ready and target-ready are both low. A data parity error is reported on an active-low error line with its own output enable. The line goes low two clocks after the bad parity was on the bus. It is then driven high for one clock and then released. An address parity error raises a one-clock system-error flag. So does a data parity error in a special-cycle transaction. A report-enable input gates both error outputs. A sticky status bit records every detected error until it is cleared.

Top module: `pci_par_unit`

## Requirements
- R1: `par_o` in cycle n+1 equals the XOR of all `ad` and `cbe_n` bits sampled in cycle n, so that the 37 bits together hold an even number of ones.
- R2: `par_oe` in cycle n+1 equals `ad_oe` of cycle n.
- R3: When `ad_oe` is low in the first cycle of a frame (frame low after a cycle with frame high), the parity in the next cycle p is checked. A mismatch with `rpt_en` high gives `serr_o` high for exactly cycle p+1.
- R4: A cycle with frame already low before it, and with `irdy_n` or `trdy_n` high, is a wait state. The parity that follows it is never checked.
- R5: A received completed data phase (both ready strobes low, `ad_oe` low) whose parity in cycle p mismatches, with `rpt_en` high and a non-special command, drives `perr_oe`=1 and `perr_o`=0 in cycle p+2.
- R6: After the last cycle of an error report, `perr_oe`=1 with `perr_o`=1 for one cycle, then `perr_oe`=0. Back-to-back errors keep the line low in consecutive cycles.
- R7: The command is the `cbe_n` value of the address phase. If it is 4'b0001 (special cycle), a data parity mismatch raises `serr_o` in cycle p+1 instead of the error line.
- R8: With `rpt_en` low during the parity cycle p, neither `perr_oe` nor `serr_o` asserts for that error, but the sticky status still sets.
- R9: `sts_err` rises in cycle p+1 after any detected mismatch. It stays high until a cycle with `sts_clr` high, which clears it in the next cycle. Setting wins over clearing.
- R10: Phases in which `ad_oe` is high are never checked.
- R11: After reset, `par_oe`, `perr_oe`, `serr_o` and `sts_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rpt_en | input | 1 | Enables reporting on `perr_o` and `serr_o` |
| sts_clr | input | 1 | Clears the sticky error status |
| ad_oe | input | 1 | This agent drives address/data this cycle |
| frame_n | input | 1 | Frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | AW | Address/data bus as seen on the pins |
| cbe_n | input | CW | Command/byte-enable lines |
| par_i | input | 1 | Parity line as seen on the pin |
| par_o | output | 1 | Generated parity |
| par_oe | output | 1 | Output enable for `par_o` |
| perr_o | output | 1 | Data parity error line, active low |
| perr_oe | output | 1 | Output enable for `perr_o` |
| serr_o | output | 1 | One-cycle system-error flag |
| sts_err | output | 1 | Sticky parity error status |

## Verification
The bench builds the block with its defaults: a 32-bit bus, 4 command lines and special-cycle code 4'b0001. This puts the full 37-bit parity fold within reach of random data. The special-cycle command can then be driven directly onto `cbe_n`. These values also allow back-to-back data phases, wait states inside a transaction, and a change of command between frames. The error-line sequence is therefore exercised in single and consecutive form, and the special-cycle redirect is hit too.

// File: rtl/pci_par_unit.sv
module pci_par_unit #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter logic [CW-1:0] SPECIAL_CMD = 4'b0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rpt_en,
  input  logic          sts_clr,
  input  logic          ad_oe,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          trdy_n,
  input  logic [AW-1:0] ad,
  input  logic [CW-1:0] cbe_n,
  input  logic          par_i,
  output logic          par_o,
  output logic          par_oe,
  output logic          perr_o,
  output logic          perr_oe,
  output logic          serr_o,
  output logic          sts_err
);
  localparam int PW = AW + CW;

  logic [PW-1:0] bus_w;
  logic          par_now;
  logic          addr_ph, data_ph;
  logic          frame_q;
  logic [CW-1:0] cmd_q;
  logic          chk_addr_q, chk_data_q, chk_spec_q, exp_q;
  logic          mism, addr_err, data_err;
  logic          err_d1, perr_low, perr_hold;

  assign bus_w   = {ad, cbe_n};
  assign par_now = ^bus_w;
  assign addr_ph = !frame_n && frame_q;
  assign data_ph = !irdy_n && !trdy_n;

  // Parity generation: one clock behind the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o  <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par_o  <= par_now;
      par_oe <= ad_oe;
    end
  end

  // Phase tracking and check arming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q    <= 1'b1;
      cmd_q      <= '0;
      chk_addr_q <= 1'b0;
      chk_data_q <= 1'b0;
      chk_spec_q <= 1'b0;
      exp_q      <= 1'b0;
    end else begin
      frame_q    <= frame_n;
      if (addr_ph) cmd_q <= cbe_n;
      chk_addr_q <= addr_ph && !ad_oe;
      chk_data_q <= data_ph && !addr_ph && !ad_oe;
      chk_spec_q <= (cmd_q == SPECIAL_CMD);
      exp_q      <= par_now;
    end
  end

  assign mism     = par_i != exp_q;
  assign addr_err = chk_addr_q && mism;
  assign data_err = chk_data_q && mism;

  // Error reporting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_d1    <= 1'b0;
      perr_low  <= 1'b0;
      perr_hold <= 1'b0;
      serr_o    <= 1'b0;
      sts_err   <= 1'b0;
    end else begin
      err_d1    <= rpt_en && data_err && !chk_spec_q;
      perr_low  <= err_d1;
      perr_hold <= perr_low && !err_d1;
      serr_o    <= rpt_en && (addr_err || (data_err && chk_spec_q));
      if (addr_err || data_err) sts_err <= 1'b1;
      else if (sts_clr)         sts_err <= 1'b0;
    end
  end

  assign perr_oe = perr_low || perr_hold;
  assign perr_o  = !perr_low;
endmodule

module pci_par_unit_chk #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rpt_en,
  input logic          sts_clr,
  input logic          ad_oe,
  input logic [AW-1:0] ad,
  input logic [CW-1:0] cbe_n,
  input logic          par_o,
  input logic          par_oe,
  input logic          perr_o,
  input logic          perr_oe,
  input logic          sts_err
);
  assert_par_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (par_o == $past(^{ad, cbe_n})));
  assert_par_oe_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (par_oe == $past(ad_oe)));
  assert_perr_high_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_o) |=> !(perr_oe && perr_o));
  assert_perr_low_then_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_o) |=> perr_oe);
  assert_perr_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_oe) |-> $past(rpt_en, 2));
  assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_err) |-> $past(sts_clr));
endmodule

bind pci_par_unit pci_par_unit_chk #(.AW(AW), .CW(CW)) chk_i (.*);

// File: tb/pci_par_unit_tb_top.sv
module pci_par_unit_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        rpt_en = 1, sts_clr = 0, ad_oe = 0;
  logic        frame_n = 1, irdy_n = 1, trdy_n = 1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        par_i = 0;
  logic        par_o, par_oe, perr_o, perr_oe, serr_o, sts_err;

  int checks = 0, failures = 0;
  bit prev_par = 0;
  int cnt_low = 0, cnt_serr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_par_unit dut_i (.*);

  // Behavioural reference model
  int e = 0;
  bit m_prevf = 1, m_par = 0, m_paroe = 0, m_low = 0, m_hold = 0, m_serr = 0, m_sticky = 0;
  int pend = 0; bit pend_exp = 0, pend_spec = 0;
  logic [3:0] m_cmd = 4'h0;
  bit low_at [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prevf = 1; m_par = 0; m_paroe = 0; m_low = 0; m_hold = 0;
      m_serr = 0; m_sticky = 0; pend = 0; m_cmd = 0;
    end else begin
      bit err, sn, nl, addr, dph;
      e++;
      err = (pend != 0) && (par_i != pend_exp);
      sn = 0;
      if (err) begin
        if (pend == 1 || pend_spec) sn = rpt_en;
        else if (rpt_en) low_at[e + 1] = 1;
      end
      if (err) m_sticky = 1; else if (sts_clr) m_sticky = 0;
      m_serr = sn;
      nl = low_at.exists(e);
      m_hold = m_low && !nl;
      m_low = nl;
      addr = !frame_n && m_prevf;
      dph  = !irdy_n && !trdy_n;
      pend = ad_oe ? 0 : (addr ? 1 : (dph ? 2 : 0));
      pend_exp = ^{ad, cbe_n};
      pend_spec = (m_cmd == 4'b0001);
      if (addr) m_cmd = cbe_n;
      m_par = ^{ad, cbe_n};
      m_paroe = ad_oe;
      m_prevf = frame_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 par_o", par_o, m_par);
    chk("R2/R10 par_oe", par_oe, m_paroe);
    chk("R5/R6 perr_oe", perr_oe, m_low || m_hold);
    chk("R5/R6 perr_o", perr_o, !m_low);
    chk("R3/R7 serr_o", serr_o, m_serr);
    chk("R9 sts_err", sts_err, m_sticky);
    if (perr_oe && !perr_o) cnt_low++;
    if (serr_o) cnt_serr++;
  end

  task automatic bus(input bit f, input bit i, input bit t, input logic [31:0] a,
                     input logic [3:0] c, input bit oe, input bit bad);
    @(negedge clk);
    #1;
    frame_n = f; irdy_n = i; trdy_n = t; ad = a; cbe_n = c; ad_oe = oe;
    par_i = prev_par ^ bad;
    prev_par = ^{a, c};
  endtask

  task automatic idle(input int n, input bit bad);
    for (int k = 0; k < n; k++) bus(1, 1, 1, 32'h0, 4'hF, 0, (k == 0) ? bad : 1'b0);
  endtask

  task automatic clear_sts();
    sts_clr = 1; idle(1, 0); sts_clr = 0; idle(1, 0);
  endtask

  initial begin
    int l0, s0;
    repeat (3) @(negedge clk);
    chk("R11 par_oe", par_oe, 0);
    chk("R11 perr_oe", perr_oe, 0);
    chk("R11 serr_o", serr_o, 0);
    chk("R11 sts_err", sts_err, 0);
    rst_n = 1;
    idle(3, 0);

    // R1 random parity patterns while sourcing
    for (int k = 0; k < 200; k++)
      bus(1, 1, 1, $urandom, 4'($urandom), 1, 0);
    idle(2, 0);

    // R10 sourced phases with wrong parity on the pin are ignored
    bus(0, 1, 1, 32'h1000_0040, 4'h7, 1, 0);
    bus(1, 0, 0, 32'hDEAD_BEEF, 4'h0, 1, 1);
    idle(6, 1);
    chk("R10 sourced not checked", sts_err, 0);

    // R4 wait states with bad parity are not checked
    l0 = cnt_low;
    bus(0, 1, 1, 32'h2000_0000, 4'h7, 0, 0);
    bus(0, 0, 1, 32'h1111_1111, 4'h0, 0, 0);
    bus(0, 0, 1, 32'h2222_2222, 4'h0, 0, 1);
    bus(1, 0, 0, 32'h3333_3333, 4'h0, 0, 1);
    idle(6, 0);
    chk("R4 wait state no error", sts_err, 0);
    chk("R4 wait state no perr", cnt_low - l0, 0);

    // R5/R6 single data parity error
    l0 = cnt_low;
    bus(0, 1, 1, 32'h3000_0000, 4'h7, 0, 0);
    bus(1, 0, 0, 32'h0F0F_0F0F, 4'h3, 0, 0);
    idle(1, 1);
    idle(6, 0);
    chk("R5 one perr cycle", cnt_low - l0, 1);
    chk("R9 sticky set", sts_err, 1);
    clear_sts();
    chk("R9 sticky cleared", sts_err, 0);

    // R6 back-to-back errors
    l0 = cnt_low;
    bus(0, 1, 1, 32'h4000_0000, 4'h7, 0, 0);
    bus(0, 0, 0, 32'hAAAA_0001, 4'h0, 0, 0);
    bus(1, 0, 0, 32'hAAAA_0002, 4'h0, 0, 1);
    idle(1, 1);
    idle(6, 0);
    chk("R6 two perr cycles", cnt_low - l0, 2);

    // R9 set wins over clear
    bus(0, 1, 1, 32'h5000_0000, 4'h7, 0, 0);
    bus(1, 0, 0, 32'h0000_0007, 4'h0, 0, 0);
    sts_clr = 1; idle(1, 1); sts_clr = 0;
    idle(1, 0);
    chk("R9 set wins over clear", sts_err, 1);
    idle(4, 0);
    clear_sts();

    // R3 address parity error
    l0 = cnt_low; s0 = cnt_serr;
    bus(0, 1, 1, 32'h6000_0010, 4'h6, 0, 0);
    bus(1, 0, 0, 32'h1234_5678, 4'h0, 0, 1);
    idle(6, 0);
    chk("R3 serr on address error", cnt_serr - s0, 1);
    chk("R3 no perr on address error", cnt_low - l0, 0);
    clear_sts();

    // R7 special cycle data error
    l0 = cnt_low; s0 = cnt_serr;
    bus(0, 1, 1, 32'h0000_0000, 4'h1, 0, 0);
    bus(1, 0, 0, 32'h0000_ABCD, 4'h0, 0, 0);
    idle(1, 1);
    idle(6, 0);
    chk("R7 special to serr", cnt_serr - s0, 1);
    chk("R7 special no perr", cnt_low - l0, 0);
    clear_sts();

    // R8 reporting disabled
    l0 = cnt_low; s0 = cnt_serr;
    rpt_en = 0;
    bus(0, 1, 1, 32'h7000_0000, 4'h7, 0, 1);
    bus(1, 0, 0, 32'h5555_AAAA, 4'h0, 0, 1);
    idle(1, 1);
    idle(6, 0);
    rpt_en = 1;
    chk("R8 no perr when disabled", cnt_low - l0, 0);
    chk("R8 no serr when disabled", cnt_serr - s0, 0);
    chk("R8 sticky still set", sts_err, 1);
    idle(2, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule